// File: doc/BRIEF.md
# Power Button Sleep-State Controller

This block turns an active-low, bouncing power button into clean system events and keeps track of the platform sleep state. The raw button is synchronised and then filtered by a counter: the filtered level moves only after the input has held its new value for a whole debounce interval. The rising edge of the filtered "pressed" level is the single trigger for every button action. In the working state the press raises a one-cycle request for the firmware or operating-system handler. In any suspend state the press wakes the system. With no power at all, the press is ignored.

A press kept down in the working state feeds a hold timer. When the hold reaches its limit, the block forces the soft-off state without waiting on any other agent. A software sleep request moves the system out of the working state. A power-loss input forces the no-power state, and a power-restore input leaves it for soft-off. All time bases count a parameterised tick, so a bench can shrink the delays.

Top module: `pwrbtn_sleep_ctrl`

## Requirements
- R1: After reset, `state_o` is S0 (code 0), both request pulses are low and `btn_level_o` is 0.
- R2: `btn_level_o` changes only after the raw button has held its new level for DEB_TICKS consecutive ticks. A low glitch shorter than that has no effect on any output.
- R3: `btn_level_o` is 1 while the filtered button is pressed (raw input low) and 0 while it is released.
- R4: A filtered press edge in S0 keeps the state at S0 and gives a single one-cycle pulse: `sci_pulse_o` when `sci_en_i` is 1, `smi_pulse_o` when it is 0. The two pulses are never high together.
- R5: A filtered press edge in any of S1..S5 (codes 1..5) moves the state to S0 and gives no pulse.
- R6: In G3 (code 7) a press changes nothing and is not remembered. `pwr_restore_i` moves G3 to S5. A press that was already held at that point does not wake the system later.
- R7: If the filtered button stays pressed in S0 for HOLD_TICKS ticks, the state moves to S5.
- R8: The hold timer runs only while the state is S0 and the button is pressed. A release, or leaving S0, clears it. A wake press starts the hold count only once S0 is reached.
- R9: Actions fire on the press edge only. Releasing the button, or holding it on after an action, causes no further state change or pulse.
- R10: `sleep_req_i` in S0 with `sleep_code_i` in 1..5 moves the state to that code. Any other code, or a request outside S0, is ignored.
- R11: `pwr_lost_i` moves any state to G3 on the next clock and overrides every other event in that cycle.
- R12: When a press edge and a sleep request arrive in the same cycle in S0, the press wins: its pulse is issued and the state stays S0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrbtn_n_i | input | 1 | Raw power button, low when pressed |
| sci_en_i | input | 1 | Selects an SCI (1) or SMI (0) request for a press in S0 |
| sleep_req_i | input | 1 | Software sleep request strobe |
| sleep_code_i | input | 3 | Target sleep state for a request (1..5 valid) |
| pwr_lost_i | input | 1 | Main power lost, forces G3 |
| pwr_restore_i | input | 1 | Power back, leaves G3 for S5 |
| state_o | output | 3 | Current state: S0..S5 = 0..5, G3 = 7 |
| smi_pulse_o | output | 1 | One-cycle SMI request |
| sci_pulse_o | output | 1 | One-cycle SCI request |
| btn_level_o | output | 1 | Filtered button level, 1 = pressed |

## Verification
Two pairs of events can land in the same cycle: the filtered press edge with a software sleep request, and the press edge with a power loss. The bench waits at a falling clock edge for the first cycle in which `btn_level_o` reads 1. That is exactly the cycle in which the press edge is presented to the state register. It then raises the competing input for that one cycle only. The results are judged against the priority order. In the first case a request pulse appears and the state stays S0. In the second case the state becomes G3 and no pulse appears.

// File: rtl/pbsc_pkg.sv
package pbsc_pkg;

  typedef enum logic [2:0] {
    PS_S0 = 3'd0,
    PS_S1 = 3'd1,
    PS_S2 = 3'd2,
    PS_S3 = 3'd3,
    PS_S4 = 3'd4,
    PS_S5 = 3'd5,
    PS_G3 = 3'd7
  } pstate_e;

  function automatic logic code_is_sleep(input logic [2:0] code);
    return (code >= 3'd1) && (code <= 3'd5);
  endfunction

endpackage

// File: rtl/pbsc_tick_gen.sv
module pbsc_tick_gen #(
  parameter int CLK_PER_TICK = 250000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_PER_TICK - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          wrap;

  assign wrap   = (cnt_q == LAST);
  assign tick_o = wrap;

  always_comb begin
    cnt_d = cnt_q + CW'(1);
    if (wrap) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pbsc_debounce.sv
module pbsc_debounce #(
  parameter int DEB_TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic btn_n_i,
  output logic pressed_o,
  output logic press_rise_o
);
  localparam int CW = $clog2(DEB_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(DEB_TICKS - 1);

  logic          meta_q, sync_q;
  logic          filt_q, filt_d;
  logic          prev_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          raw_pressed;

  assign raw_pressed = ~sync_q;

  // Counter restarts whenever the input agrees with the filtered level,
  // so any bounce back restarts the interval.
  always_comb begin
    filt_d = filt_q;
    cnt_d  = cnt_q;
    if (raw_pressed == filt_q) begin
      cnt_d = '0;
    end else if (tick_i) begin
      if (cnt_q == LAST) begin
        filt_d = raw_pressed;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      filt_q <= 1'b0;
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      meta_q <= btn_n_i;
      sync_q <= meta_q;
      filt_q <= filt_d;
      prev_q <= filt_q;
      cnt_q  <= cnt_d;
    end
  end

  assign pressed_o    = filt_q;
  assign press_rise_o = filt_q & ~prev_q;
endmodule

// File: rtl/pbsc_hold_timer.sv
module pbsc_hold_timer #(
  parameter int HOLD_TICKS = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic run_i,
  output logic expire_o
);
  localparam int CW = $clog2(HOLD_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);
  localparam logic [CW-1:0] DONE = CW'(HOLD_TICKS);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          exp_q, exp_d;

  // Saturates at DONE so that one hold gives one expiry.
  always_comb begin
    cnt_d = cnt_q;
    exp_d = 1'b0;
    if (!run_i) begin
      cnt_d = '0;
    end else if (tick_i && (cnt_q != DONE)) begin
      cnt_d = cnt_q + CW'(1);
      if (cnt_q == LAST) exp_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      exp_q <= exp_d;
    end
  end

  assign expire_o = exp_q;
endmodule

// File: rtl/pbsc_state_fsm.sv
module pbsc_state_fsm
  import pbsc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       press_edge_i,
  input  logic       override_i,
  input  logic       sci_en_i,
  input  logic       sleep_req_i,
  input  logic [2:0] sleep_code_i,
  input  logic       pwr_lost_i,
  input  logic       pwr_restore_i,
  output pstate_e    state_o,
  output logic       smi_o,
  output logic       sci_o
);
  pstate_e st_q, st_d;
  logic    smi_q, smi_d, sci_q, sci_d;

  // Priority: power loss, G3 exit, hold override, press edge, sleep request.
  always_comb begin
    st_d  = st_q;
    smi_d = 1'b0;
    sci_d = 1'b0;
    if (pwr_lost_i) begin
      st_d = PS_G3;
    end else if (st_q == PS_G3) begin
      if (pwr_restore_i) st_d = PS_S5;
    end else if (override_i && (st_q != PS_S5)) begin
      st_d = PS_S5;
    end else if (press_edge_i) begin
      if (st_q == PS_S0) begin
        if (sci_en_i) sci_d = 1'b1;
        else          smi_d = 1'b1;
      end else begin
        st_d = PS_S0;
      end
    end else if (sleep_req_i && (st_q == PS_S0) && code_is_sleep(sleep_code_i)) begin
      st_d = pstate_e'(sleep_code_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PS_S0;
      smi_q <= 1'b0;
      sci_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      smi_q <= smi_d;
      sci_q <= sci_d;
    end
  end

  assign state_o = st_q;
  assign smi_o   = smi_q;
  assign sci_o   = sci_q;
endmodule

// File: rtl/pwrbtn_sleep_ctrl.sv
module pwrbtn_sleep_ctrl
  import pbsc_pkg::*;
#(
  parameter int CLK_PER_TICK = 250000,
  parameter int DEB_TICKS    = 16,
  parameter int HOLD_TICKS   = 4000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwrbtn_n_i,
  input  logic       sci_en_i,
  input  logic       sleep_req_i,
  input  logic [2:0] sleep_code_i,
  input  logic       pwr_lost_i,
  input  logic       pwr_restore_i,
  output logic [2:0] state_o,
  output logic       smi_pulse_o,
  output logic       sci_pulse_o,
  output logic       btn_level_o
);
  logic    rs1_q, rs2_q;
  logic    irst_n;
  logic    tick;
  logic    pressed, press_rise;
  logic    hold_run, hold_expire;
  pstate_e st;

  // Reset asserts at once, releases on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign irst_n = rs2_q;

  pbsc_tick_gen #(.CLK_PER_TICK(CLK_PER_TICK)) u_tick (
    .clk    (clk),
    .rst_n  (irst_n),
    .tick_o (tick)
  );

  pbsc_debounce #(.DEB_TICKS(DEB_TICKS)) u_deb (
    .clk          (clk),
    .rst_n        (irst_n),
    .tick_i       (tick),
    .btn_n_i      (pwrbtn_n_i),
    .pressed_o    (pressed),
    .press_rise_o (press_rise)
  );

  assign hold_run = pressed && (st == PS_S0);

  pbsc_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk      (clk),
    .rst_n    (irst_n),
    .tick_i   (tick),
    .run_i    (hold_run),
    .expire_o (hold_expire)
  );

  pbsc_state_fsm u_fsm (
    .clk           (clk),
    .rst_n         (irst_n),
    .press_edge_i  (press_rise),
    .override_i    (hold_expire),
    .sci_en_i      (sci_en_i),
    .sleep_req_i   (sleep_req_i),
    .sleep_code_i  (sleep_code_i),
    .pwr_lost_i    (pwr_lost_i),
    .pwr_restore_i (pwr_restore_i),
    .state_o       (st),
    .smi_o         (smi_pulse_o),
    .sci_o         (sci_pulse_o)
  );

  assign state_o     = st;
  assign btn_level_o = pressed;
endmodule

// File: rtl/pbsc_chk.sv
module pbsc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_lost_i,
  input logic       pwr_restore_i,
  input logic [2:0] state_o,
  input logic       smi_pulse_o,
  input logic       sci_pulse_o
);
  // R4
  no_dual_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(smi_pulse_o && sci_pulse_o));
  // R4
  smi_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smi_pulse_o |=> !smi_pulse_o);
  // R4
  sci_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sci_pulse_o |=> !sci_pulse_o);
  // R5
  pulse_in_s0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_pulse_o || sci_pulse_o) |-> (state_o == 3'd0 && $past(state_o) == 3'd0));
  // R11
  pwr_lost_g3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_lost_i |=> (state_o == 3'd7));
  // R6
  g3_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd7 && !pwr_restore_i) |=> (state_o == 3'd7));
  // R6
  g3_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd7 && pwr_restore_i && !pwr_lost_i) |=> (state_o == 3'd5));
  // R1
  state_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_o != 3'd6);
endmodule

bind pwrbtn_sleep_ctrl pbsc_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .pwr_lost_i    (pwr_lost_i),
  .pwr_restore_i (pwr_restore_i),
  .state_o       (state_o),
  .smi_pulse_o   (smi_pulse_o),
  .sci_pulse_o   (sci_pulse_o)
);

// File: tb/tb_pwrbtn_sleep_ctrl.sv
module tb_pwrbtn_sleep_ctrl;
  localparam int DIV  = 4;
  localparam int DEB  = 4;
  localparam int HOLD = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pb_n, sci_en, sreq, lost, restore;
  logic [2:0] scode;
  logic [2:0] state;
  logic       smi, sci, lvl;

  int checks = 0;
  int fails  = 0;
  int smi_cnt = 0;
  int sci_cnt = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  pwrbtn_sleep_ctrl #(.CLK_PER_TICK(DIV), .DEB_TICKS(DEB), .HOLD_TICKS(HOLD)) dut (
    .clk(clk), .rst_n(rst_n), .pwrbtn_n_i(pb_n), .sci_en_i(sci_en),
    .sleep_req_i(sreq), .sleep_code_i(scode), .pwr_lost_i(lost),
    .pwr_restore_i(restore), .state_o(state), .smi_pulse_o(smi),
    .sci_pulse_o(sci), .btn_level_o(lvl)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (smi) smi_cnt <= smi_cnt + 1;
    if (sci) sci_cnt <= sci_cnt + 1;
  end

  always @(negedge clk) begin
    if (cyc == 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Returns at the first falling edge where the filtered level reads pressed.
  task automatic press_wait();
    pb_n = 1'b0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (lvl) return;
    end
    chk("R3 press seen", 0, 1);
  endtask

  task automatic release_wait();
    pb_n = 1'b1;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (!lvl) return;
    end
    chk("R3 release seen", 1, 0);
  endtask

  task automatic sleep_to(input logic [2:0] c);
    scode = c; sreq = 1'b1;
    @(negedge clk);
    sreq = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int s0, c0;
    rst_n = 1'b0; pb_n = 1'b1; sci_en = 1'b0; sreq = 1'b0; scode = 3'd0;
    lost = 1'b0; restore = 1'b0;
    cycles(3);
    rst_n = 1'b1;
    cycles(4);
    chk("R1 state", state, 0);
    chk("R1 smi", smi, 0);
    chk("R1 sci", sci, 0);
    chk("R1 level", lvl, 0);

    // R2: short glitches are filtered out
    for (int g = 1; g <= 8; g++) begin
      pb_n = 1'b0; cycles(g); pb_n = 1'b1; cycles(2 * DEB * DIV);
      chk("R2 glitch level", lvl, 0);
    end
    chk("R2 glitch pulses", smi_cnt + sci_cnt, 0);

    // R4 / R3 / R9: press in S0 for both enable settings
    for (int e = 0; e < 2; e++) begin
      sci_en = e[0];
      s0 = smi_cnt; c0 = sci_cnt;
      press_wait();
      chk("R3 level pressed", lvl, 1);
      cycles(2);
      chk("R4 smi count", smi_cnt - s0, e == 0 ? 1 : 0);
      chk("R4 sci count", sci_cnt - c0, e == 1 ? 1 : 0);
      chk("R4 state S0", state, 0);
      cycles(20);
      release_wait();
      cycles(10);
      chk("R3 level released", lvl, 0);
      chk("R9 no pulse on release", smi_cnt + sci_cnt - s0 - c0, 1);
    end

    // R10 / R5: sleep code sweep, then wake
    for (int c = 0; c < 8; c++) begin
      sleep_to(c[2:0]);
      chk("R10 sleep code", state, (c >= 1 && c <= 5) ? c : 0);
      if (c >= 1 && c <= 5) begin
        sleep_to(3'd2);
        chk("R10 request outside S0", state, c);
        s0 = smi_cnt + sci_cnt;
        press_wait(); @(negedge clk);
        chk("R5 wake to S0", state, 0);
        cycles(2);
        chk("R5 no pulse on wake", smi_cnt + sci_cnt, s0);
        release_wait(); cycles(4);
      end
    end

    // R11 / R6: power loss, press in G3, restore while held
    sleep_to(3'd3);
    lost = 1'b1; @(negedge clk); lost = 1'b0; @(negedge clk);
    chk("R11 lost to G3", state, 7);
    s0 = smi_cnt + sci_cnt;
    press_wait(); cycles(30);
    chk("R6 G3 ignores press", state, 7);
    restore = 1'b1; @(negedge clk); restore = 1'b0; @(negedge clk);
    chk("R6 restore to S5", state, 5);
    cycles(40);
    chk("R6 held press not latched", state, 5);
    chk("R6 no pulses", smi_cnt + sci_cnt, s0);
    release_wait(); cycles(4);
    press_wait(); @(negedge clk);
    chk("R5 wake from S5", state, 0);
    release_wait(); cycles(4);

    // R7 / R9: long hold in S0
    press_wait();
    cycles((HOLD - 1) * DIV - 1);
    chk("R7 before hold limit", state, 0);
    cycles(2 * DIV + 4);
    chk("R7 hold forces S5", state, 5);
    cycles(40);
    chk("R9 still held no wake", state, 5);
    release_wait(); cycles(4);

    // R8: wake press keeps holding; count starts in S0
    press_wait(); @(negedge clk);
    chk("R8 wake", state, 0);
    cycles((HOLD - 1) * DIV - 2);
    chk("R8 count from S0", state, 0);
    cycles(2 * DIV + 4);
    chk("R8 hold after wake", state, 5);
    release_wait(); cycles(4);
    press_wait(); @(negedge clk); release_wait(); cycles(4);

    // R8: release clears the count
    press_wait(); cycles(HOLD * DIV / 2 + 4); release_wait(); cycles(2);
    press_wait(); cycles(HOLD * DIV / 2 + 4);
    chk("R8 release clears count", state, 0);
    // R8: leaving S0 while held stops the timer
    sleep_to(3'd2);
    cycles(HOLD * DIV * 2);
    chk("R8 no count outside S0", state, 2);
    release_wait(); cycles(4);
    press_wait(); @(negedge clk); release_wait(); cycles(4);

    // R12: press edge and sleep request in the same cycle
    sci_en = 1'b1;
    c0 = sci_cnt;
    press_wait();
    scode = 3'd2; sreq = 1'b1; @(negedge clk); sreq = 1'b0;
    @(negedge clk);
    chk("R12 state stays S0", state, 0);
    chk("R12 pulse issued", sci_cnt - c0, 1);
    release_wait(); cycles(4);

    // R11: power loss beats a press edge in the same cycle
    s0 = smi_cnt + sci_cnt;
    press_wait();
    lost = 1'b1; @(negedge clk); lost = 1'b0; cycles(3);
    chk("R11 loss wins", state, 7);
    chk("R11 no pulse", smi_cnt + sci_cnt, s0);
    release_wait();
    restore = 1'b1; @(negedge clk); restore = 1'b0; @(negedge clk);
    chk("R6 restore", state, 5);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule